// File: doc/BRIEF.md
# Receive Data Port Aligner

This block stands between a receive data FIFO of 32-bit words and a host read port. Each host read strobe yields exactly one 32-bit word on the following cycle. The block frames the words of each packet. When a packet starts, it takes the payload length in words from a separate length queue. It then returns a programmable number of leading zero words, followed by the payload words taken from the data FIFO. Last come trailing zero words that bring the packet's total length to a chosen alignment.

The block keeps the read pointer of the data FIFO. The pointer wraps at a FIFO depth that need not be a power of two, and the data storage outside the block is read at that pointer. The block also tracks how many words the data FIFO holds and how many entries the receive status FIFO holds, so that an information register can report both counts.

Two commands act on the stream. A skip command throws away the rest of the current packet, or the whole next packet if none has started. A dump command empties the data FIFO, the status FIFO and the length queue together. A read when nothing is left to return gives a zero word and flags an underflow.

Top module: `rx_port_aligner`

## Requirements
- R1: After reset, `rd_valid`, `rd_err` and `lq_pop` are 0, and `dq_used`, `sq_used` and `dq_head` are 0.
- R2: A read (`rd_en` high, `skip_pkt` and `dump_all` low) raises `rd_valid` with the returned word on `rd_data` in the next cycle.
- R3: A read or skip made while no payload or pad of the current packet remains takes the next entry from the length queue, if one is present. `lq_pop` is high in that same cycle.
- R4: At packet start the value of `lead_zeros` (0 to 7) is captured. That many zero words are returned before the first payload word.
- R5: At packet start `end_align` is captured. With a value of 1, zero words pad (lead zeros + payload words) up to a multiple of 4. With a value of 2, they pad it up to a multiple of 8. The values 0 and 3 add no pad.
- R6: Within a packet the words come in this order: lead zeros, then payload words in FIFO order, then pad zeros.
- R7: A read with no lead zero, payload or pad left and an empty length queue returns 0 with `rd_err` high.
- R8: `skip_pkt` during a packet drops its remaining lead zeros and pad. It also moves `dq_head` forward past its remaining payload words, and `dq_used` drops by the same number.
- R9: `skip_pkt` with no packet in progress starts the next packet from the length queue and discards all of its payload.
- R10: `dump_all` clears `dq_used` and `sq_used` and pulses `lq_flush`. It abandons the packet in progress and leaves `dq_head` unchanged, so the next read underflows.
- R11: `dq_head` advances by one for each payload word read and wraps from DEPTH-1 to 0.
- R12: `dq_used` rises by one for each `dq_push` and falls by one for each payload word consumed. `sq_used` counts `sq_push` minus `sq_pop`, and neither moves past full or below empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 32 | Word returned for the previous read |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| rd_err | output | 1 | The returned word was an underflow |
| skip_pkt | input | 1 | Discard the rest of the current or next packet |
| dump_all | input | 1 | Empty data FIFO, status FIFO and length queue |
| lead_zeros | input | 3 | Zero words placed before the payload |
| end_align | input | 2 | End alignment: 1 gives 4 words, 2 gives 8 words, otherwise none |
| dq_push | input | 1 | Writer stored one word in the data FIFO |
| dq_head | output | clog2(DEPTH) | Data FIFO read pointer |
| dq_rdata | input | 32 | Data FIFO word at `dq_head` |
| dq_used | output | clog2(DEPTH+1) | Data FIFO occupancy in words |
| lq_valid | input | 1 | Length queue holds an entry |
| lq_len | input | LW | Payload word count at the head of the length queue |
| lq_pop | output | 1 | Consume the length queue head |
| lq_flush | output | 1 | Empty the length queue |
| sq_push | input | 1 | Status FIFO gained an entry |
| sq_pop | input | 1 | Status FIFO lost an entry |
| sq_used | output | clog2(SDEPTH+1) | Status FIFO occupancy |

## Verification
The properties rely on certain writer behaviour. The writer never pushes into a full data FIFO. It enqueues a nonzero length only after all of that packet's words are stored, and a packet never exceeds the words held. They also rely on the host never raising `skip_pkt` or `dump_all` in the same cycle as a read. The stimulus obeys all of these rules: its packets fit the small 13-word FIFO, each length goes in after its data, and commands and reads are driven in separate cycles. The stimulus also keeps pushes and reads apart, so every occupancy step has a single cause.

// File: rtl/rx_port_aligner.sv
module rx_port_aligner #(
  parameter int DEPTH  = 2640,
  parameter int LW     = 11,
  parameter int SDEPTH = 176,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(SDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  output logic          rd_valid,
  output logic          rd_err,
  input  logic          skip_pkt,
  input  logic          dump_all,
  input  logic [2:0]    lead_zeros,
  input  logic [1:0]    end_align,
  input  logic          dq_push,
  output logic [PW-1:0] dq_head,
  input  logic [31:0]   dq_rdata,
  output logic [CW-1:0] dq_used,
  input  logic          lq_valid,
  input  logic [LW-1:0] lq_len,
  output logic          lq_pop,
  output logic          lq_flush,
  input  logic          sq_push,
  input  logic          sq_pop,
  output logic [SW-1:0] sq_used
);
  localparam int HW = PW + LW + 1;

  logic [2:0]    off_q, pad_q;
  logic [LW-1:0] size_q;

  wire idle  = (size_q == '0) && (pad_q == '0);
  wire start = (rd_en | skip_pkt) & ~dump_all & idle & lq_valid;
  wire rd_go = rd_en & ~skip_pkt & ~dump_all;

  assign lq_pop   = start;
  assign lq_flush = dump_all;

  logic [LW:0] span;
  logic [2:0]  neg, pad_new;
  assign span = {1'b0, lq_len} + (LW+1)'(lead_zeros);
  assign neg  = 3'(~span[2:0] + 3'd1);
  always_comb
    case (end_align)
      2'd1:    pad_new = {1'b0, neg[1:0]};
      2'd2:    pad_new = neg;
      default: pad_new = 3'd0;
    endcase

  wire [2:0]    e_off  = start ? lead_zeros : off_q;
  wire [LW-1:0] e_size = start ? lq_len     : size_q;
  wire [2:0]    e_pad  = start ? pad_new    : pad_q;

  logic [2:0]    n_off, n_pad;
  logic [LW-1:0] n_size;
  logic [31:0]   word;
  logic          take, under;
  always_comb begin
    n_off = e_off; n_size = e_size; n_pad = e_pad;
    word = '0; take = 1'b0; under = 1'b0;
    if (e_off != '0)       n_off = e_off - 3'd1;
    else if (e_size != '0) begin n_size = e_size - 1'b1; take = 1'b1; word = dq_rdata; end
    else if (e_pad != '0)  n_pad = e_pad - 3'd1;
    else                   under = 1'b1;
  end

  logic [LW-1:0] adv;
  assign adv = dump_all ? '0 : skip_pkt ? e_size : LW'(rd_en & take);

  logic [HW-1:0] hsum;
  assign hsum = HW'(dq_head) + HW'(adv);
  wire [PW-1:0] head_nx = (hsum >= HW'(DEPTH)) ? PW'(hsum - HW'(DEPTH)) : PW'(hsum);

  wire sq_inc = sq_push & (sq_used != SW'(SDEPTH));
  wire sq_dec = sq_pop & (sq_used != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      off_q <= '0; size_q <= '0; pad_q <= '0;
      dq_head <= '0; dq_used <= '0; sq_used <= '0;
      rd_data <= '0; rd_valid <= 1'b0; rd_err <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      rd_err   <= rd_go & under;
      rd_data  <= rd_go ? word : '0;
      dq_head  <= head_nx;
      if (dump_all) begin
        off_q <= '0; size_q <= '0; pad_q <= '0;
        dq_used <= '0; sq_used <= '0;
      end else begin
        dq_used <= dq_used + CW'(dq_push) - CW'(adv);
        sq_used <= sq_used + SW'(sq_inc) - SW'(sq_dec);
        if (skip_pkt) begin
          off_q <= '0; size_q <= '0; pad_q <= '0;
        end else if (rd_en) begin
          off_q <= n_off; size_q <= n_size; pad_q <= n_pad;
        end
      end
    end
endmodule

// File: rtl/rx_port_aligner_chk.sv
module rx_port_aligner_chk #(
  parameter int DEPTH = 2640,
  parameter int PW = 12,
  parameter int CW = 12,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [31:0]   rd_data,
  input logic          rd_valid,
  input logic          rd_err,
  input logic          skip_pkt,
  input logic          dump_all,
  input logic          dq_push,
  input logic [PW-1:0] dq_head,
  input logic [CW-1:0] dq_used,
  input logic          lq_valid,
  input logic          lq_pop,
  input logic [SW-1:0] sq_used
);
  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !skip_pkt && !dump_all |=> rd_valid);
  // R3
  lq_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lq_pop |-> lq_valid);
  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_err |-> rd_data == 32'd0);
  // R10
  dump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_all |=> dq_used == '0 && sq_used == '0 && !rd_valid);
  // R11
  head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_head < PW'(DEPTH));
  // R11
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en && !skip_pkt |=> $stable(dq_head));
  // R12
  used_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_used <= CW'(DEPTH));
  // R12
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_push && !rd_en && !skip_pkt && !dump_all |=> dq_used == CW'($past(dq_used) + 1'b1));
endmodule

bind rx_port_aligner rx_port_aligner_chk #(.DEPTH(DEPTH), .PW(PW), .CW(CW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
  .rd_err(rd_err), .skip_pkt(skip_pkt), .dump_all(dump_all), .dq_push(dq_push),
  .dq_head(dq_head), .dq_used(dq_used), .lq_valid(lq_valid), .lq_pop(lq_pop),
  .sq_used(sq_used));

// File: tb/sim_rx_port_aligner.sv
module sim_rx_port_aligner;
  localparam int D = 13, LW = 5, SD = 4;
  localparam int PW = $clog2(D), CW = $clog2(D + 1), SW = $clog2(SD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 0, skip_pkt = 0, dump_all = 0, dq_push = 0, sq_push = 0, sq_pop = 0;
  logic [2:0] lead_zeros = 0;
  logic [1:0] end_align = 0;
  logic lq_valid = 0;
  logic [LW-1:0] lq_len = 0;
  logic [31:0] rd_data, dq_rdata;
  logic rd_valid, rd_err, lq_pop, lq_flush;
  logic [PW-1:0] dq_head;
  logic [CW-1:0] dq_used;
  logic [SW-1:0] sq_used;

  always #10 clk = ~clk;

  logic [31:0] mem [D];
  int tail = 0, exp_head = 0, exp_used = 0;
  int lq[$];
  logic [32:0] expq[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  assign dq_rdata = mem[dq_head];

  rx_port_aligner #(.DEPTH(D), .LW(LW), .SDEPTH(SD)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_err(rd_err), .skip_pkt(skip_pkt), .dump_all(dump_all), .lead_zeros(lead_zeros),
    .end_align(end_align), .dq_push(dq_push), .dq_head(dq_head), .dq_rdata(dq_rdata),
    .dq_used(dq_used), .lq_valid(lq_valid), .lq_len(lq_len), .lq_pop(lq_pop),
    .lq_flush(lq_flush), .sq_push(sq_push), .sq_pop(sq_pop), .sq_used(sq_used));

  always @(posedge clk) begin
    if (lq_flush) lq.delete();
    else if (lq_pop && lq.size() != 0) void'(lq.pop_front());
    lq_valid <= lq.size() != 0;
    lq_len   <= (lq.size() != 0) ? LW'(lq[0]) : '0;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rd_valid) begin
    if (expq.size() == 0) chk(0, "R2 unexpected word", int'(rd_data), -1);
    else begin
      logic [32:0] e;
      e = expq.pop_front();
      chk({rd_err, rd_data} == e, e[32] ? "R7 underflow" : "R6 stream word",
          int'(rd_data) ^ (int'(rd_err) << 31), int'(e[31:0]) ^ (int'(e[32]) << 31));
    end
  end

  task automatic push_pkt(int n, int base);
    for (int i = 0; i < n; i++) begin
      mem[tail] = base + i;
      tail = (tail + 1) % D;
      dq_push = 1;
      @(negedge clk);
      dq_push = 0;
    end
    lq.push_back(n);
    lq_valid = 1; lq_len = LW'(lq[0]);
    exp_used += n;
  endtask

  task automatic rd(bit e, int d);
    expq.push_back({e, 32'(d)});
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic read_pkt(int n, int base, int off, int al);
    int m, pad;
    m = off + n;
    pad = (al == 1) ? (4 - m % 4) % 4 : (al == 2) ? (8 - m % 8) % 8 : 0;
    lead_zeros = 3'(off); end_align = 2'(al);
    for (int i = 0; i < off; i++) rd(0, 0);
    for (int i = 0; i < n; i++) rd(0, base + i);
    for (int i = 0; i < pad; i++) rd(0, 0);
    exp_used -= n;
    exp_head = (exp_head + n) % D;
    @(negedge clk);
  endtask

  task automatic pulse_skip();
    skip_pkt = 1; @(negedge clk); skip_pkt = 0; @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_valid == 0 && rd_err == 0 && lq_pop == 0, "R1 flags", {rd_valid, rd_err, lq_pop}, 0);
    chk(dq_used == 0 && sq_used == 0 && dq_head == 0, "R1 counts", int'(dq_used) + int'(sq_used) + int'(dq_head), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R6 plain packet
    push_pkt(3, 'h100);
    chk(int'(dq_used) == exp_used, "R12 used after push", dq_used, exp_used);
    read_pkt(3, 'h100, 0, 0);
    chk(int'(dq_head) == exp_head, "R11 head", dq_head, exp_head);
    chk(int'(dq_used) == exp_used, "R12 used after read", dq_used, exp_used);
    chk(lq.size() == 0, "R3 length taken", lq.size(), 0);

    // R4 R5 lead zeros and 4-word alignment
    push_pkt(5, 'h200);
    read_pkt(5, 'h200, 2, 1);
    // R5 8-word alignment
    push_pkt(3, 'h300);
    read_pkt(3, 'h300, 0, 2);
    // R5 mode 3 no pad, R11 wrap past DEPTH
    push_pkt(6, 'h400);
    read_pkt(6, 'h400, 1, 3);
    chk(int'(dq_head) == 4, "R11 wrap", dq_head, 4);

    // R7 underflow
    rd(1, 0);
    @(negedge clk);

    // R8 skip mid-packet
    push_pkt(5, 'h500);
    lead_zeros = 0; end_align = 1;
    rd(0, 'h500); rd(0, 'h501);
    @(negedge clk);
    pulse_skip();
    exp_head = (exp_head + 5) % D; exp_used -= 5;
    chk(int'(dq_head) == exp_head, "R8 head after skip", dq_head, exp_head);
    chk(int'(dq_used) == exp_used, "R8 used after skip", dq_used, exp_used);
    push_pkt(2, 'h600);
    read_pkt(2, 'h600, 0, 0);

    // R9 skip with no packet started
    push_pkt(3, 'h700);
    push_pkt(2, 'h800);
    pulse_skip();
    exp_head = (exp_head + 3) % D; exp_used -= 3;
    chk(int'(dq_used) == exp_used, "R9 used after idle skip", dq_used, exp_used);
    chk(lq.size() == 1, "R9 one length left", lq.size(), 1);
    read_pkt(2, 'h800, 0, 0);

    // R12 status occupancy, saturating
    for (int i = 0; i < 6; i++) begin sq_push = 1; @(negedge clk); end
    sq_push = 0;
    chk(sq_used == SW'(SD), "R12 status full", sq_used, SD);
    sq_pop = 1; @(negedge clk); sq_pop = 0;
    chk(sq_used == SW'(SD - 1), "R12 status pop", sq_used, SD - 1);

    // R10 dump
    push_pkt(4, 'h900);
    rd(0, 'h900);
    exp_head = (exp_head + 1) % D;
    @(negedge clk);
    dump_all = 1; @(negedge clk); dump_all = 0; @(negedge clk);
    chk(dq_used == 0 && sq_used == 0, "R10 counts cleared", int'(dq_used) + int'(sq_used), 0);
    chk(lq.size() == 0, "R10 length queue flushed", lq.size(), 0);
    chk(int'(dq_head) == exp_head, "R10 head kept", dq_head, exp_head);
    rd(1, 0);
    @(negedge clk);
    tail = exp_head; exp_used = 0;
    push_pkt(2, 'hA00);
    read_pkt(2, 'hA00, 0, 0);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R2 all words returned", expq.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule